// File: doc/BRIEF.md
# Linear Photodiode Array Scan Sequencer

This block is the digital sequencer of a linear photodiode array. Its inputs are a serial start line and a clock. A start sampled high on a rising clock edge launches a one-hot select token. The token walks one position per clock across all output positions, in this order: a pair of leading dummy positions, then the real pixels, then a pair of trailing dummy positions. One more clock after the last position empties the chain, so a full readout takes one clock more than there are positions.

Alongside the token, the block produces several control signals:
- an integrator-reset signal that is held for a fixed number of clocks after each start;
- an integration-window signal;
- a sample/hold disconnect signal;
- an output-enable for the analog driver, which releases the output to high impedance once the last position has been read;
- a binary pixel index, which stands in for the analog sample.

The block also tracks power-up initialisation. A scan is marked trustworthy only if at least one complete readout has finished before it. A start that arrives while a readout is still running is reported as a protocol error, and the sequence restarts from the first position.

Top module: `lsa_ctrl`

## Requirements
- R1: A high level on `start_i` at a rising edge of `clk` makes, from the next cycle on, `out_en_o`, `sh_hold_o` and `int_rst_o` high, `integ_o` low, `pix_idx_o` equal to 0 and `sel_o` bit 0 set.
- R2: While `out_en_o` is high and no new start is sampled, `pix_idx_o` increments by one per clock from 0 to 131. `sel_o` has exactly the bit numbered `pix_idx_o` set.
- R3: `pix_real_o` is high only while `out_en_o` is high and `pix_idx_o` lies in 2..129 (the 128 real pixels). It is low for dummy indices 0, 1, 130 and 131.
- R4: The clock edge that follows index 131 (the 133rd edge counting the start edge) selects nothing. After it, `sel_o` is all zero, `out_en_o` and `sh_hold_o` are low, and `pix_idx_o` is 0.
- R5: `int_rst_o` stays high for exactly 18 cycles after the start edge and falls when `pix_idx_o` reaches 18. `integ_o` rises in that same cycle, and the two are never high together.
- R6: `integ_o` stays high past the end of readout until the next start. At the edge that samples that start, `integ_o` falls and `sh_hold_o` rises together.
- R7: `scan_valid_o` is low throughout the first scan after reset. It is high during a scan that starts after a complete readout.
- R8: A start sampled while `out_en_o` is high gives a one-cycle pulse on `proto_err_o`. It restarts the token at index 0 and restarts the 18-cycle integrator reset.
- R9: An aborted readout does not count as initialisation. A scan restarted after reset but before any complete readout still has `scan_valid_o` low.
- R10: During and right after reset, every output is low and `sel_o` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Serial start, sampled on rising edge |
| sel_o | output | 132 | One-hot position select token |
| pix_idx_o | output | 8 | Index of the selected position (0 when idle) |
| pix_real_o | output | 1 | Selected position is a real pixel |
| out_en_o | output | 1 | Analog output driven (low means high impedance) |
| sh_hold_o | output | 1 | Sampling capacitors disconnected from integrators |
| int_rst_o | output | 1 | Integrators held in reset |
| integ_o | output | 1 | Light integration window open |
| scan_valid_o | output | 1 | Current readout follows a completed initialisation |
| proto_err_o | output | 1 | One-cycle pulse: start arrived mid-readout |

## Verification
The bench targets the boundaries of the scan:
- the dummy/real edges at indices 1/2 and 129/130, where an off-by-one flags a dummy as real or drops a real pixel;
- the 18-cycle reset window, where a counter off by one moves the integration start by a clock;
- the extra re-initialisation clock, where a design that idles one edge early or late leaves the output driven or cuts the last dummy.

It also restarts a scan mid-readout. A design that fails to clear the chain would show two set select bits. A design that counts the aborted scan as initialisation would mark the following scan valid too early.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

  // Control flags that leave the phase controller together
  typedef struct packed {
    logic int_rst;
    logic integ;
    logic hold;
  } lsa_phase_t;

  localparam lsa_phase_t PHASE_RESET = '{int_rst: 1'b0, integ: 1'b0, hold: 1'b0};

endpackage

// File: rtl/lsa_token_chain.sv
module lsa_token_chain #(
  parameter int unsigned N_POS = 132
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  output logic [N_POS-1:0] token
);

  logic [N_POS-1:0] token_q;
  logic [N_POS-1:0] token_d;

  // Stage 0 loads on launch. Every later stage copies its neighbour,
  // unless a launch clears the chain for a restart.
  always_comb token_d[0] = launch;

  for (genvar g = 1; g < N_POS; g++) begin : g_stage
    always_comb token_d[g] = launch ? 1'b0 : token_q[g-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) token_q <= '0;
    else        token_q <= token_d;
  end

  assign token = token_q;

endmodule

// File: rtl/lsa_pos_counter.sv
module lsa_pos_counter #(
  parameter int unsigned N_POS = 132,
  localparam int unsigned IDX_W = $clog2(N_POS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             active,
  output logic [IDX_W-1:0] idx
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_POS - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;

  always_comb begin
    idx_en = launch | active;
    if (launch)             idx_d = '0;
    else if (idx_q == LAST) idx_d = '0;
    else                    idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign idx = idx_q;

endmodule

// File: rtl/lsa_phase_ctrl.sv
module lsa_phase_ctrl
  import lsa_pkg::*;
#(
  parameter int unsigned RST_CLKS = 18,
  localparam int unsigned RC_W = $clog2(RST_CLKS + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch,
  input  logic       active,
  input  logic       last_pos,
  output lsa_phase_t phase,
  output logic       scan_ok,
  output logic       proto_err
);

  localparam logic [RC_W-1:0] RC_END = RC_W'(RST_CLKS - 1);

  lsa_phase_t      ph_q, ph_d;
  logic [RC_W-1:0] rc_q, rc_d;
  logic            init_q, init_d;
  logic            ok_q, ok_d;
  logic            err_q, err_d;

  always_comb begin
    ph_d   = ph_q;
    rc_d   = rc_q;
    init_d = init_q;
    ok_d   = ok_q;
    err_d  = 1'b0;
    if (launch) begin
      // New scan: freeze samples, reset integrators, restart the count
      ph_d.hold    = 1'b1;
      ph_d.int_rst = 1'b1;
      ph_d.integ   = 1'b0;
      rc_d         = '0;
      ok_d         = init_q;
      err_d        = active;
    end else begin
      if (ph_q.int_rst) begin
        if (rc_q == RC_END) begin
          ph_d.int_rst = 1'b0;
          ph_d.integ   = 1'b1;
        end else begin
          rc_d = rc_q + 1'b1;
        end
      end
      if (last_pos) begin
        // Re-initialisation clock: samplers track again, setup complete
        ph_d.hold = 1'b0;
        init_d    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PHASE_RESET;
      rc_q   <= '0;
      init_q <= 1'b0;
      ok_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      rc_q   <= rc_d;
      init_q <= init_d;
      ok_q   <= ok_d;
      err_q  <= err_d;
    end
  end

  assign phase     = ph_q;
  assign scan_ok   = ok_q;
  assign proto_err = err_q;

endmodule

// File: rtl/lsa_ctrl.sv
module lsa_ctrl
  import lsa_pkg::*;
#(
  parameter int unsigned N_LEAD   = 2,
  parameter int unsigned N_REAL   = 128,
  parameter int unsigned N_TAIL   = 2,
  parameter int unsigned RST_CLKS = 18,
  localparam int unsigned N_POS = N_LEAD + N_REAL + N_TAIL,
  localparam int unsigned IDX_W = $clog2(N_POS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic [N_POS-1:0] sel_o,
  output logic [IDX_W-1:0] pix_idx_o,
  output logic             pix_real_o,
  output logic             out_en_o,
  output logic             sh_hold_o,
  output logic             int_rst_o,
  output logic             integ_o,
  output logic             scan_valid_o,
  output logic             proto_err_o
);

  localparam logic [IDX_W-1:0] REAL_LO = IDX_W'(N_LEAD);
  localparam logic [IDX_W-1:0] REAL_HI = IDX_W'(N_LEAD + N_REAL - 1);

  logic [N_POS-1:0] token;
  logic [IDX_W-1:0] idx;
  logic             active;
  lsa_phase_t       phase;
  logic             scan_ok;
  logic             err;

  lsa_token_chain #(.N_POS(N_POS)) u_chain (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (start_i),
    .token  (token)
  );

  assign active = |token;

  lsa_pos_counter #(.N_POS(N_POS)) u_pos (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (start_i),
    .active (active),
    .idx    (idx)
  );

  lsa_phase_ctrl #(.RST_CLKS(RST_CLKS)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (start_i),
    .active    (active),
    .last_pos  (token[N_POS-1]),
    .phase     (phase),
    .scan_ok   (scan_ok),
    .proto_err (err)
  );

  assign sel_o        = token;
  assign pix_idx_o    = idx;
  assign pix_real_o   = active && (idx >= REAL_LO) && (idx <= REAL_HI);
  assign out_en_o     = active;
  assign sh_hold_o    = phase.hold;
  assign int_rst_o    = phase.int_rst;
  assign integ_o      = phase.integ;
  assign scan_valid_o = scan_ok & active;
  assign proto_err_o  = err;

endmodule

// File: rtl/lsa_ctrl_chk.sv
module lsa_ctrl_chk #(
  parameter int unsigned N_LEAD   = 2,
  parameter int unsigned N_REAL   = 128,
  parameter int unsigned N_TAIL   = 2,
  parameter int unsigned RST_CLKS = 18,
  localparam int unsigned N_POS = N_LEAD + N_REAL + N_TAIL,
  localparam int unsigned IDX_W = $clog2(N_POS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [N_POS-1:0] sel_o,
  input logic [IDX_W-1:0] pix_idx_o,
  input logic             pix_real_o,
  input logic             out_en_o,
  input logic             sh_hold_o,
  input logic             int_rst_o,
  input logic             integ_o,
  input logic             scan_valid_o,
  input logic             proto_err_o
);

  localparam logic [IDX_W-1:0] LASTI = IDX_W'(N_POS - 1);

  AST_LAUNCH_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (out_en_o && sel_o[0] && pix_idx_o == '0 && int_rst_o && sh_hold_o && !integ_o)); // R1

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_o) && (out_en_o == (sel_o != '0))); // R2

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en_o && !start_i && pix_idx_o != LASTI) |=>
      (out_en_o && pix_idx_o == IDX_W'($past(pix_idx_o) + 1'b1))); // R2

  AST_REAL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_real_o |-> (out_en_o && pix_idx_o >= IDX_W'(N_LEAD) && pix_idx_o < IDX_W'(N_LEAD + N_REAL))); // R3

  AST_FINAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en_o && !start_i && pix_idx_o == LASTI) |=> (!out_en_o && sel_o == '0 && !sh_hold_o)); // R4

  AST_RST_INTEG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(int_rst_o && integ_o)); // R5

  AST_VALID_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    scan_valid_o |-> out_en_o); // R7

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && out_en_o) |=> proto_err_o); // R8

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i) |=> !proto_err_o); // R8

endmodule

bind lsa_ctrl lsa_ctrl_chk #(
  .N_LEAD(N_LEAD), .N_REAL(N_REAL), .N_TAIL(N_TAIL), .RST_CLKS(RST_CLKS)
) i_chk (.*);

// File: tb/test_lsa_ctrl.sv
module test_lsa_ctrl;

  localparam int NPOS = 132;

  logic            clk;
  logic            rst_n;
  logic            start_i;
  logic [NPOS-1:0] sel_o;
  logic [7:0]      pix_idx_o;
  logic            pix_real_o, out_en_o, sh_hold_o, int_rst_o, integ_o;
  logic            scan_valid_o, proto_err_o;

  int n_run  = 0;
  int n_fail = 0;

  lsa_ctrl i_lsa_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sel_o(sel_o),
    .pix_idx_o(pix_idx_o), .pix_real_o(pix_real_o), .out_en_o(out_en_o),
    .sh_hold_o(sh_hold_o), .int_rst_o(int_rst_o), .integ_o(integ_o),
    .scan_valid_o(scan_valid_o), .proto_err_o(proto_err_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Vector: {cycle after start edge[8], idx[8], real, int_rst, out_en, integ}
  localparam int NV = 10;
  localparam logic [19:0] VEC [NV] = '{
    {8'd0,   8'd0,   4'b0110},
    {8'd1,   8'd1,   4'b0110},
    {8'd2,   8'd2,   4'b1110},
    {8'd17,  8'd17,  4'b1110},
    {8'd18,  8'd18,  4'b1011},
    {8'd64,  8'd64,  4'b1011},
    {8'd129, 8'd129, 4'b1011},
    {8'd130, 8'd130, 4'b0011},
    {8'd131, 8'd131, 4'b0011},
    {8'd132, 8'd0,   4'b0001}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic do_reset();
    rst_n   = 1'b0;
    start_i = 1'b0;
    step();
    step();
    rst_n = 1'b1;
    step();
  endtask

  // Launch a start; on return the sample point is cycle 0 of the scan
  task automatic launch();
    start_i = 1'b1;
    step();
    start_i = 1'b0;
  endtask

  task automatic walk_scan(input logic exp_valid);
    int cur = 0;
    for (int v = 0; v < NV; v++) begin
      while (cur < int'(VEC[v][19:12])) begin
        step();
        cur++;
        if (out_en_o) begin
          n_run++;
          if (sel_o !== (NPOS'(1) << pix_idx_o)) begin
            n_fail++;
            $display("FAIL R2: sel %0h not matching idx %0d", sel_o, pix_idx_o);
          end
        end
      end
      check("R2 idx", pix_idx_o, VEC[v][11:4]);
      check("R3 real", pix_real_o, VEC[v][3]);
      check("R5 int_rst", int_rst_o, VEC[v][2]);
      check("R4 out_en", out_en_o, VEC[v][1]);
      check("R5 integ", integ_o, VEC[v][0]);
      if (VEC[v][1]) check("R7 valid", scan_valid_o, exp_valid);
      else           check("R4 sel idle", (sel_o == '0), 1);
    end
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    do_reset();
    // R10 reset state
    check("R10 sel", sel_o, 0);
    check("R10 flags", {pix_real_o, out_en_o, sh_hold_o, int_rst_o, integ_o, scan_valid_o, proto_err_o}, 0);

    // First scan after reset: invalid (R7), full table walk (R1..R5)
    launch();
    check("R1 hold", sh_hold_o, 1);
    check("R1 sel0", sel_o[0], 1);
    walk_scan(1'b0);
    check("R4 hold released", sh_hold_o, 0);
    step(); step(); step();
    check("R6 integ kept", integ_o, 1);
    check("R4 still idle", out_en_o, 0);

    // Second scan: valid, integ falls with hold rise (R6)
    launch();
    check("R6 integ fell", integ_o, 0);
    check("R6 hold rose", sh_hold_o, 1);
    check("R8 no err", proto_err_o, 0);
    walk_scan(1'b1);

    // Restart mid-readout after fresh reset (R8, R9)
    do_reset();
    launch();
    for (int i = 0; i < 10; i++) step();
    check("R2 idx10", pix_idx_o, 10);
    launch();
    check("R8 err", proto_err_o, 1);
    check("R8 idx", pix_idx_o, 0);
    check("R8 int_rst", int_rst_o, 1);
    check("R8 single sel", sel_o, 1);
    check("R9 valid low", scan_valid_o, 0);
    cnt = 1;
    step();
    check("R8 err pulse", proto_err_o, 0);
    while (int_rst_o && cnt < 40) begin
      cnt++;
      step();
    end
    check("R8 reset len", cnt, 18);
    check("R5 idx at integ", pix_idx_o, 18);
    check("R9 valid still low", scan_valid_o, 0);
    while (out_en_o && cnt < 400) begin
      cnt++;
      step();
    end
    check("R4 end cycle", cnt, 132);
    step();
    launch();
    check("R7 valid after init", scan_valid_o, 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule